// File: doc/BRIEF.md
# PWM Time-Base Counter

This block produces the time reference for a pulse-width modulator. A two-stage prescaler divides the system clock into a time-base tick, and a 16-bit counter moves on each tick. It can count up, count down, count up then down, or hold still. The counter measures its cycle against a period value. That period is written either straight into the active register or into a shadow copy, which the counter picks up when it reaches zero. A two-bit run field lets the counter run freely, stop after one more step, or stop once the current cycle has finished. While stopped, the counter keeps its value until free running is selected again.

Software-facing logic writes the control word and the period through two plain write strobes. Each strobe is taken in the cycle it is high, so the interface has no handshake and no back-pressure. A downstream action qualifier uses the outputs: the count, the tick strobe, the count direction, and one-cycle pulses for the zero match and the period match.

Top module: `pwm_timebase`

## Requirements
- R1: Control bits 1:0 select the counting mode. In 00 the counter counts up and wraps to 0 on the tick after it equals the period. In 01 it counts down and loads the period on the tick after it equals 0. In 10 it counts up to the period and back down to 0. In 11 it holds its value.
- R2: The tick strobe `tb_tick` is high once every F system clocks. F = 2^C × H, where C is control bits 12:10 and H is 1 when control bits 9:7 are 0 and twice their value otherwise.
- R3: The count changes only on a clock edge at which `tb_tick` is high, and it changes by one step.
- R4: With control bit 3 at 1, a period write replaces the active period from the next edge. With bit 3 at 0, the write goes only to the shadow register, and the shadow value becomes active on the tick at which the count is 0.
- R5: Control bits 15:14 set the run behaviour. 00 stops the counter after one more step. 01 stops it when the cycle ends: at the period in up mode, and at 0 in down or up-down mode. 10 or 11 lets it run freely.
- R6: A stopped counter holds its value and produces no event pulses. Writing a run field of 10 or 11 resumes counting from the held value on the next tick.
- R7: `evt_zero` and `evt_period` are high for exactly the one clock in which the count has just moved to 0 or to the period. Neither pulse is produced while the mode is 11.
- R8: `tb_dir_up` is 1 when the last step counted upward and 0 when it counted downward. In up-down mode it changes on the step that leaves the period or leaves 0.
- R9: After reset the count is 0, the control word and both period registers are 0, the counter is stopped, `tb_dir_up` is 1, and there are no event pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ctrl_wr_en | input | 1 | Write strobe for the control word |
| ctrl_wr_data | input | 16 | Control word: run 15:14, C 12:10, H field 9:7, period-load select 3, mode 1:0 |
| prd_wr_en | input | 1 | Write strobe for the period |
| prd_wr_data | input | CNT_W | Period value |
| tb_count | output | CNT_W | Current counter value |
| tb_tick | output | 1 | Time-base clock enable strobe |
| tb_dir_up | output | 1 | Direction of the last counter step |
| evt_zero | output | 1 | Count has just become 0 |
| evt_period | output | 1 | Count has just become the period |

## Verification
The bench tries each counting mode with a small period. This separates the wrap to zero, the reload from zero, and the turn at both ends, and it reads the direction flag at each turn. For the prescaler, a table of divider settings is timed by counting the clocks between ticks. The table includes power-of-two-only, doubled-factor-only and mixed products, up to the largest factor. A period write made in the middle of a cycle tells shadow loading apart from immediate loading: with a shadow write the old period still ends the current cycle, and with an immediate write the cycle ends early. Both stop behaviours are driven mid-cycle in the up and down modes, and a resume test shows that counting restarts from the value held while stopped.

// File: rtl/pwm_timebase_pkg.sv
package pwm_timebase_pkg;

  localparam int CTRL_W = 16;
  localparam int DIV_W  = 3;

  typedef enum logic [1:0] {
    MODE_UP     = 2'b00,
    MODE_DOWN   = 2'b01,
    MODE_UPDOWN = 2'b10,
    MODE_FREEZE = 2'b11
  } cnt_mode_e;

  // Control word layout; bit positions are fixed by software.
  typedef struct packed {
    logic [1:0]       run;      // 15:14
    logic             spare13;  // 13
    logic [DIV_W-1:0] pow_sel;  // 12:10 power-of-two stage
    logic [DIV_W-1:0] mul_sel;  // 9:7 doubled-factor stage
    logic [2:0]       spare6;   // 6:4
    logic             prd_imm;  // 3
    logic             spare2;   // 2
    cnt_mode_e        mode;     // 1:0
  } ctrl_t;

endpackage

// File: rtl/ptb_prescale.sv
module ptb_prescale #(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] pow_sel,
  input  logic [DIV_W-1:0] mul_sel,
  output logic             tick
);

  localparam int MAX_SEL  = (1 << DIV_W) - 1;
  localparam int MAX_FACT = (1 << MAX_SEL) * (2 * MAX_SEL);
  localparam int FACT_W   = $clog2(MAX_FACT + 1);

  logic [DIV_W:0]    mul_fact;
  logic [FACT_W-1:0] factor;
  logic [FACT_W-1:0] div_cnt;

  // Second stage: 1 when the field is 0, otherwise twice the field.
  assign mul_fact = (mul_sel == '0) ? (DIV_W+1)'(1) : {mul_sel, 1'b0};
  assign factor   = FACT_W'(mul_fact) << pow_sel;

  // >= keeps the divider sane when the factor shrinks mid-count.
  assign tick = (div_cnt >= (factor - FACT_W'(1)));

  always_ff @(posedge clk) begin
    if (rst)       div_cnt <= '0;
    else if (tick) div_cnt <= '0;
    else           div_cnt <= div_cnt + FACT_W'(1);
  end

  // R2: with an unchanged factor above one, ticks never come back to back.
  p_tick_spacing_r2: assert property (@(posedge clk) disable iff (rst)
    (tick && factor > FACT_W'(1)) |=> (!tick || factor != $past(factor)));

endmodule

// File: rtl/ptb_period.sv
module ptb_period #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             imm,
  input  logic             load_zero,
  output logic [CNT_W-1:0] prd_cur
);

  logic [CNT_W-1:0] shadow_q;
  logic [CNT_W-1:0] active_q;

  // The value the counter steps against this cycle; at a zero tick the
  // shadow content is what becomes active.
  assign prd_cur = load_zero ? shadow_q : active_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= '0;
      active_q <= '0;
    end else begin
      if (wr_en) shadow_q <= wr_data;
      if (wr_en && imm)   active_q <= wr_data;
      else if (load_zero) active_q <= shadow_q;
    end
  end

  // R4: immediate write lands in the active period on the next edge.
  p_imm_write_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && imm) |=> (active_q == $past(wr_data)));

  // R4: the zero tick moves the shadow into the active period.
  p_shadow_load_r4: assert property (@(posedge clk) disable iff (rst)
    (load_zero && !(wr_en && imm)) |=> (active_q == $past(shadow_q)));

endmodule

// File: rtl/ptb_counter.sv
module ptb_counter
  import pwm_timebase_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  cnt_mode_e        mode,
  input  logic [1:0]       run,
  input  logic [CNT_W-1:0] prd,
  output logic [CNT_W-1:0] count,
  output logic             dir_up,
  output logic             evt_zero,
  output logic             evt_period
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             dir_q, dir_nxt;
  logic             halted_q;
  logic             run_free, live, step, cyc_end;

  assign run_free = run[1];
  assign live     = run_free || !halted_q;
  assign step     = tick && live && (mode != MODE_FREEZE);

  always_comb begin
    cnt_nxt = cnt_q;
    dir_nxt = dir_q;
    unique case (mode)
      MODE_UP: begin
        dir_nxt = 1'b1;
        cnt_nxt = (cnt_q >= prd) ? '0 : cnt_q + ONE;
      end
      MODE_DOWN: begin
        dir_nxt = 1'b0;
        cnt_nxt = (cnt_q == '0 || cnt_q > prd) ? prd : cnt_q - ONE;
      end
      MODE_UPDOWN: begin
        if (dir_q) begin
          if (cnt_q >= prd) begin
            dir_nxt = 1'b0;
            cnt_nxt = (prd == '0) ? '0 : prd - ONE;
          end else begin
            cnt_nxt = cnt_q + ONE;
          end
        end else begin
          if (cnt_q == '0) begin
            dir_nxt = 1'b1;
            cnt_nxt = (prd == '0) ? '0 : ONE;
          end else if (cnt_q > prd) begin
            cnt_nxt = prd;
          end else begin
            cnt_nxt = cnt_q - ONE;
          end
        end
      end
      default: ;
    endcase
  end

  // End of a counting cycle: the period when counting up only, zero otherwise.
  assign cyc_end = (mode == MODE_UP) ? (cnt_nxt == prd) : (cnt_nxt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q      <= '0;
      dir_q      <= 1'b1;
      halted_q   <= 1'b1;
      evt_zero   <= 1'b0;
      evt_period <= 1'b0;
    end else begin
      evt_zero   <= step && (cnt_nxt == '0);
      evt_period <= step && (cnt_nxt == prd);
      if (step) begin
        cnt_q <= cnt_nxt;
        dir_q <= dir_nxt;
      end
      if (run_free)                      halted_q <= 1'b0;
      else if (step && (!run[0] || cyc_end)) halted_q <= 1'b1;
    end
  end

  assign count  = cnt_q;
  assign dir_up = dir_q;

  // R1: hold mode leaves the count untouched.
  p_freeze_hold_r1: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_FREEZE) |=> $stable(cnt_q));

  // R3: no tick, no movement.
  p_tick_gate_r3: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt_q));

  // R6: a stopped counter keeps its value and stays silent.
  p_halt_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (halted_q && !run_free) |=> ($stable(cnt_q) && !evt_zero && !evt_period));

  // R7: a zero pulse always accompanies a zero count.
  p_zero_match_r7: assert property (@(posedge clk) disable iff (rst)
    evt_zero |-> (cnt_q == '0));

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_timebase_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctrl_wr_en,
  input  logic [15:0]      ctrl_wr_data,
  input  logic             prd_wr_en,
  input  logic [CNT_W-1:0] prd_wr_data,
  output logic [CNT_W-1:0] tb_count,
  output logic             tb_tick,
  output logic             tb_dir_up,
  output logic             evt_zero,
  output logic             evt_period
);

  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] prd_cur;
  logic             load_zero;
  logic [4:0]       ctrl_spare_unused;

  always_ff @(posedge clk) begin
    if (rst)             ctrl_q <= '0;
    else if (ctrl_wr_en) ctrl_q <= ctrl_t'(ctrl_wr_data);
  end

  assign ctrl_spare_unused = {ctrl_q.spare13, ctrl_q.spare6, ctrl_q.spare2};

  ptb_prescale #(.DIV_W(DIV_W)) u_prescale (
    .clk     (clk),
    .rst     (rst),
    .pow_sel (ctrl_q.pow_sel),
    .mul_sel (ctrl_q.mul_sel),
    .tick    (tb_tick)
  );

  assign load_zero = tb_tick && (tb_count == '0);

  ptb_period #(.CNT_W(CNT_W)) u_period (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (prd_wr_en),
    .wr_data   (prd_wr_data),
    .imm       (ctrl_q.prd_imm),
    .load_zero (load_zero),
    .prd_cur   (prd_cur)
  );

  ptb_counter #(.CNT_W(CNT_W)) u_counter (
    .clk        (clk),
    .rst        (rst),
    .tick       (tb_tick),
    .mode       (ctrl_q.mode),
    .run        (ctrl_q.run),
    .prd        (prd_cur),
    .count      (tb_count),
    .dir_up     (tb_dir_up),
    .evt_zero   (evt_zero),
    .evt_period (evt_period)
  );

endmodule

// File: tb/pwm_timebase_tb.sv
module pwm_timebase_tb;

  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             ctrl_wr_en = 1'b0;
  logic [15:0]      ctrl_wr_data = '0;
  logic             prd_wr_en = 1'b0;
  logic [CNT_W-1:0] prd_wr_data = '0;
  logic [CNT_W-1:0] tb_count;
  logic             tb_tick, tb_dir_up, evt_zero, evt_period;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  pwm_timebase #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst(rst),
    .ctrl_wr_en(ctrl_wr_en), .ctrl_wr_data(ctrl_wr_data),
    .prd_wr_en(prd_wr_en), .prd_wr_data(prd_wr_data),
    .tb_count(tb_count), .tb_tick(tb_tick), .tb_dir_up(tb_dir_up),
    .evt_zero(evt_zero), .evt_period(evt_period)
  );

  // {power field, doubled field, expected clocks per tick}
  localparam logic [16:0] PS_TAB [0:7] = '{
    {3'd0, 3'd0, 11'd1},    {3'd1, 3'd0, 11'd2},
    {3'd0, 3'd1, 11'd2},    {3'd0, 3'd2, 11'd4},
    {3'd2, 3'd3, 11'd24},   {3'd3, 3'd1, 11'd16},
    {3'd1, 3'd7, 11'd28},   {3'd7, 3'd7, 11'd1792}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // All drivers below are called at a falling edge.
  task automatic wr_ctrl(input logic [15:0] v);
    ctrl_wr_en = 1'b1; ctrl_wr_data = v;
    @(negedge clk);
    ctrl_wr_en = 1'b0;
  endtask

  task automatic wr_prd(input logic [CNT_W-1:0] v);
    prd_wr_en = 1'b1; prd_wr_data = v;
    @(negedge clk);
    prd_wr_en = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1; ctrl_wr_en = 1'b0; prd_wr_en = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic nxt(input string req, input int ec, input int ez, input int ep);
    @(negedge clk);
    chk(req, int'(tb_count), ec);
    chk({req, " events"}, int'({evt_zero, evt_period}), ez * 2 + ep);
  endtask

  // Stopped, immediate load, chosen mode; period P; then free-run.
  task automatic start_mode(input logic [1:0] mode, input int p);
    do_reset();
    wr_ctrl({14'h0002, mode});
    wr_prd(CNT_W'(p));
    wr_ctrl({14'h3002, mode});
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R9 watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    @(negedge clk);
    do_reset();

    // R9 reset state, and the counter stays put while stopped
    chk("R9 count", int'(tb_count), 0);
    chk("R9 dir", int'(tb_dir_up), 1);
    chk("R9 events", int'({evt_zero, evt_period}), 0);
    repeat (3) @(negedge clk);
    chk("R9 stopped after reset", int'(tb_count), 0);

    // R2 prescaler table walk
    for (int i = 0; i < 8; i++) begin
      int n;
      int exp;
      exp = int'(PS_TAB[i][10:0]);
      wr_ctrl({2'b11, 1'b0, PS_TAB[i][16:14], PS_TAB[i][13:11], 7'b0000011});
      n = 0;
      while (!tb_tick && n < 4000) begin @(negedge clk); n++; end
      n = 0;
      do begin @(negedge clk); n++; end while (!tb_tick && n < 4000);
      chk("R2 clocks per tick", n, exp);
    end

    // R1 up mode with period 4, R7 pulses
    start_mode(2'b00, 4);
    chk("R1 up start", int'(tb_count), 0);
    for (int k = 1; k <= 10; k++)
      nxt("R1 up", k % 5, int'(k % 5 == 0), int'(k % 5 == 4));
    // R7 hold mode: one step with old mode at the write, then frozen, silent
    wr_ctrl(16'hC00B);
    chk("R1 freeze entry", int'(tb_count), 1);
    for (int k = 0; k < 4; k++) nxt("R7 freeze", 1, 0, 0);

    // R1 down mode with period 3
    start_mode(2'b01, 3);
    for (int k = 1; k <= 8; k++) begin
      int e;
      e = 3 - ((k - 1) % 4);
      nxt("R1 down", e, int'(e == 0), int'(e == 3));
    end

    // R1 up-down with period 3, R8 direction
    start_mode(2'b10, 3);
    for (int k = 1; k <= 13; k++) begin
      int v;
      int e;
      v = k % 6;
      e = (v <= 3) ? v : 6 - v;
      nxt("R1 updown", e, int'(e == 0), int'(e == 3));
      chk("R8 direction", int'(tb_dir_up), int'(v >= 1 && v <= 3));
    end

    // R4 shadow load: new period takes effect only after the wrap
    do_reset();
    wr_prd(16'd5);
    wr_ctrl(16'hC000);
    chk("R4 shadow start", int'(tb_count), 0);
    for (int k = 1; k <= 3; k++) nxt("R4 shadow", k, 0, 0);
    prd_wr_en = 1'b1; prd_wr_data = 16'd2;
    @(negedge clk);
    prd_wr_en = 1'b0;
    chk("R4 shadow write", int'(tb_count), 4);
    nxt("R4 shadow old period", 5, 0, 1);
    nxt("R4 shadow wrap", 0, 1, 0);
    nxt("R4 shadow", 1, 0, 0);
    nxt("R4 shadow new period", 2, 0, 1);
    nxt("R4 shadow", 0, 1, 0);

    // R4 immediate load: period cut mid-cycle
    start_mode(2'b00, 6);
    for (int k = 1; k <= 3; k++) nxt("R4 imm", k, 0, 0);
    prd_wr_en = 1'b1; prd_wr_data = 16'd3;
    @(negedge clk);
    prd_wr_en = 1'b0;
    chk("R4 imm write", int'(tb_count), 4);
    nxt("R4 imm early wrap", 0, 1, 0);
    nxt("R4 imm", 1, 0, 0);
    nxt("R4 imm", 2, 0, 0);
    nxt("R4 imm new period", 3, 0, 1);

    // R5 stop after one step
    start_mode(2'b00, 5);
    nxt("R5 step", 1, 0, 0);
    nxt("R5 step", 2, 0, 0);
    wr_ctrl(16'h0008);
    chk("R5 step write", int'(tb_count), 3);
    nxt("R5 one more step", 4, 0, 0);
    for (int k = 0; k < 3; k++) nxt("R5 stopped", 4, 0, 0);

    // R5 stop at cycle end in up mode, then R6 hold and resume
    start_mode(2'b00, 5);
    nxt("R5 cycle up", 1, 0, 0);
    nxt("R5 cycle up", 2, 0, 0);
    wr_ctrl(16'h4008);
    chk("R5 cycle write", int'(tb_count), 3);
    nxt("R5 cycle up", 4, 0, 0);
    nxt("R5 cycle up end", 5, 0, 1);
    for (int k = 0; k < 3; k++) nxt("R6 held", 5, 0, 0);
    wr_ctrl(16'hC008);
    chk("R6 resume write", int'(tb_count), 5);
    nxt("R6 resume", 0, 1, 0);
    nxt("R6 resume", 1, 0, 0);

    // R5 stop at cycle end in down mode
    start_mode(2'b01, 5);
    for (int k = 0; k < 3; k++) nxt("R5 cycle down", 5 - k, 0, int'(k == 0));
    wr_ctrl(16'h4009);
    chk("R5 cycle down write", int'(tb_count), 2);
    nxt("R5 cycle down", 1, 0, 0);
    nxt("R5 cycle down end", 0, 1, 0);
    for (int k = 0; k < 2; k++) nxt("R5 down stopped", 0, 0, 0);

    // R3 count moves only on tick edges, by one step (factor 4, period 9)
    do_reset();
    wr_ctrl(16'h0108);
    wr_prd(16'd9);
    wr_ctrl(16'hC108);
    begin
      int ticks;
      ticks = 0;
      for (int k = 0; k < 40; k++) begin
        int pc;
        int e;
        bit pt;
        pc = int'(tb_count);
        pt = tb_tick;
        if (pt) ticks++;
        @(negedge clk);
        e = pt ? ((pc >= 9) ? 0 : pc + 1) : pc;
        chk("R3 tick gating", int'(tb_count), e);
      end
      chk("R3 tick count", ticks, 10);
    end

    finish_run();
  end

endmodule